// File: doc/BRIEF.md
# Prioritized Interrupt Level Arbiter

This block gathers a set of peripheral interrupt sources and presents a single request to the processor. Each source has a latched cause flag, an enable bit, two bits that together send the source to a DMA-style request path instead of the processor, and a 3-bit priority level. Among the flagged, enabled sources that are not sent to DMA, the arbiter picks the one with the highest level. It then reports a request, that source's level and a vector number.

Software sets the enables, the DMA steering bits and the priority fields through a simple write port. The same port clears cause flags by writing ones. Peripherals raise flags with one-cycle trigger pulses. The DMA channel path and the processor's acceptance logic are outside this block.

Top module: `itcArb`

## Requirements
- R1: A CPU request is raised only for a source whose cause flag and enable bit are both 1. While `irqReq` is 0, `irqLevel` and `irqVector` are both 0.
- R2: A one-cycle pulse on `srcTrig[i]` sets flag i whether or not source i is enabled. The flag stays set until it is cleared, so enabling the source later raises the request.
- R3: Among the eligible sources, the one with the highest priority level wins, and `irqLevel` equals that level.
- R4: If two eligible sources have the same level, the one with the lower index wins.
- R5: A source whose priority field is 0 never produces a CPU request.
- R6: `irqVector` equals `VEC_BASE` plus the index of the winning source.
- R7: A source whose DMA request bit and DMA enable bit are both 1 is left out of CPU arbitration. Either bit alone has no effect.
- R8: A write to address 3 clears each flag whose data bit is 1. Flags whose data bit is 0 are unchanged.
- R9: If a trigger pulse and a clear of the same flag fall in the same cycle, the flag ends up set.
- R10: The outputs are registered. They change on the clock edge after the edge that changed the flags, enables, steering bits or priorities.
- R11: The write addresses are: 0 for the enable mask, 1 for the DMA request bits, 2 for the DMA enable bits, 3 for the flag clear, and 4+i for the priority of source i, taken from `wrData[2:0]`. Reset sets every register to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcTrig | input | NUM_SRC | One-cycle trigger pulses, one per source |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Register write address |
| wrData | input | NUM_SRC | Register write data |
| irqReq | output | 1 | Interrupt request to the processor |
| irqLevel | output | 3 | Priority level of the winning source |
| irqVector | output | VEC_W | Vector number of the winning source |

## Verification
The output-stability check assumes that the only causes of change are writes and trigger pulses. No other path alters the flags, enables or priorities. It also assumes that `wrEn` and `srcTrig` are held low during reset, which the bench does. The bench changes all inputs on the falling clock edge and returns every strobe and trigger to 0 after one cycle. Because of this, each pulse or write lasts exactly one clock, and idle periods really are idle.

// File: rtl/itcArbPkg.sv
package itcArbPkg;
  localparam int LVL_W = 3;
  localparam int PRI_BASE_ADDR = 4;

  typedef struct packed {
    logic setEn;
    logic setDmaReq;
    logic setDmaEn;
    logic clrFlag;
  } regStrobe_t;
endpackage

// File: rtl/itcArbCtrl.sv
module itcArbCtrl
  import itcArbPkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int ADDR_W = 4
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  output regStrobe_t        strobe,
  output logic [NUM_SRC-1:0] priSel
);
  always_comb begin
    strobe.setEn     = wrEn && (wrAddr == ADDR_W'(0));
    strobe.setDmaReq = wrEn && (wrAddr == ADDR_W'(1));
    strobe.setDmaEn  = wrEn && (wrAddr == ADDR_W'(2));
    strobe.clrFlag   = wrEn && (wrAddr == ADDR_W'(3));
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_sel
    assign priSel[i] = wrEn && (wrAddr == ADDR_W'(PRI_BASE_ADDR + i));
  end
endmodule

// File: rtl/itcArbData.sv
module itcArbData
  import itcArbPkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int VEC_W = 8,
  parameter int VEC_BASE = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  regStrobe_t         strobe,
  input  logic [NUM_SRC-1:0] priSel,
  input  logic [NUM_SRC-1:0] wrData,
  input  logic [NUM_SRC-1:0] srcTrig,
  output logic               irqReq,
  output logic [LVL_W-1:0]   irqLevel,
  output logic [VEC_W-1:0]   irqVector
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0] flags, intEn, dmaReq, dmaEn, eligible;
  logic [LVL_W-1:0]   pri [NUM_SRC];
  logic [LVL_W-1:0]   bestLvl;
  logic [IDX_W-1:0]   bestIdx;
  logic               found;

  // Trigger set takes precedence over a same-cycle clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      flags  <= '0;
      intEn  <= '0;
      dmaReq <= '0;
      dmaEn  <= '0;
    end else begin
      flags <= (flags & ~(strobe.clrFlag ? wrData : '0)) | srcTrig;
      if (strobe.setEn)     intEn  <= wrData;
      if (strobe.setDmaReq) dmaReq <= wrData;
      if (strobe.setDmaEn)  dmaEn  <= wrData;
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_pri
    always_ff @(posedge clk) begin
      if (!rstN)          pri[i] <= '0;
      else if (priSel[i]) pri[i] <= wrData[LVL_W-1:0];
    end
  end

  assign eligible = flags & intEn & ~(dmaReq & dmaEn);

  // Ascending scan with strict compare: ties go to lower index, level 0 never wins
  always_comb begin
    bestLvl = '0;
    bestIdx = '0;
    found   = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (eligible[i] && (pri[i] > bestLvl)) begin
        bestLvl = pri[i];
        bestIdx = IDX_W'(i);
        found   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqReq    <= 1'b0;
      irqLevel  <= '0;
      irqVector <= '0;
    end else begin
      irqReq    <= found;
      irqLevel  <= found ? bestLvl : '0;
      irqVector <= found ? (VEC_W'(VEC_BASE) + VEC_W'(bestIdx)) : '0;
    end
  end
endmodule

// File: rtl/itcArb.sv
module itcArb
  import itcArbPkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int VEC_W = 8,
  parameter int VEC_BASE = 16,
  parameter int ADDR_W = $clog2(NUM_SRC + PRI_BASE_ADDR)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcTrig,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [NUM_SRC-1:0] wrData,
  output logic               irqReq,
  output logic [2:0]         irqLevel,
  output logic [VEC_W-1:0]   irqVector
);
  regStrobe_t         strobe;
  logic [NUM_SRC-1:0] priSel;

  itcArbCtrl #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) i_ctrl (
    .wrEn(wrEn), .wrAddr(wrAddr), .strobe(strobe), .priSel(priSel)
  );

  itcArbData #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) i_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .priSel(priSel),
    .wrData(wrData), .srcTrig(srcTrig),
    .irqReq(irqReq), .irqLevel(irqLevel), .irqVector(irqVector)
  );
endmodule

// File: rtl/itcArbChk.sv
module itcArbChk #(
  parameter int NUM_SRC = 8,
  parameter int VEC_W = 8,
  parameter int VEC_BASE = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] srcTrig,
  input logic               wrEn,
  input logic               irqReq,
  input logic [2:0]         irqLevel,
  input logic [VEC_W-1:0]   irqVector
);
  logic idle;
  assign idle = !wrEn && (srcTrig == '0);

  // R1
  idle_outputs_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !irqReq |-> (irqLevel == 3'd0 && irqVector == '0));

  // R5
  no_level_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (irqLevel != 3'd0));

  // R6
  vector_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (irqVector >= VEC_W'(VEC_BASE) && irqVector < VEC_W'(VEC_BASE + NUM_SRC)));

  // R10
  quiet_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(idle) && idle) |=> $stable({irqReq, irqLevel, irqVector}));
endmodule

bind itcArb itcArbChk #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) i_chk (
  .clk(clk), .rstN(rstN), .srcTrig(srcTrig), .wrEn(wrEn),
  .irqReq(irqReq), .irqLevel(irqLevel), .irqVector(irqVector)
);

// File: tb/test_itcArb.sv
module test_itcArb;
  localparam int N = 8;
  localparam int VW = 8;
  localparam int VB = 16;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [N-1:0]  srcTrig = '0;
  logic          wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [N-1:0]  wrData = '0;
  logic          irqReq;
  logic [2:0]    irqLevel;
  logic [VW-1:0] irqVector;

  int total = 0;
  int bad = 0;

  itcArb #(.NUM_SRC(N), .VEC_W(VW), .VEC_BASE(VB)) i_itcArb (
    .clk(clk), .rstN(rstN), .srcTrig(srcTrig), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .irqReq(irqReq), .irqLevel(irqLevel), .irqVector(irqVector)
  );

  always #2 clk = ~clk;

  task automatic check(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic checkOut(input string tag, input int req, input int lvl, input int vec);
    check({tag, " req"}, int'(irqReq), req);
    check({tag, " level"}, int'(irqLevel), lvl);
    check({tag, " vector"}, int'(irqVector), vec);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic regWrite(input int a, input int d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = AW'(a); wrData = N'(d);
    @(negedge clk);
    wrEn = 1'b0; wrAddr = '0; wrData = '0;
  endtask

  task automatic pulse(input int mask);
    @(negedge clk);
    srcTrig = N'(mask);
    @(negedge clk);
    srcTrig = '0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic testReset();
    doReset();
    settle();
    checkOut("R11 reset", 0, 0, 0);
    pulse(8'hFF); settle();
    checkOut("R11 reset enables zero", 0, 0, 0);
  endtask

  task automatic testSingleAndLatency();
    doReset();
    regWrite(4 + 2, 5);
    regWrite(0, 8'h04);
    pulse(8'h04);
    checkOut("R10 not yet", 0, 0, 0);
    settle();
    checkOut("R10/R6 single", 1, 5, VB + 2);
  endtask

  task automatic testEnableLatch();
    doReset();
    regWrite(4 + 3, 2);
    pulse(8'h08); settle();
    checkOut("R1 disabled", 0, 0, 0);
    regWrite(0, 8'h08); settle();
    checkOut("R2 latched flag", 1, 2, VB + 3);
  endtask

  task automatic testPriority();
    doReset();
    regWrite(4 + 1, 3);
    regWrite(4 + 6, 6);
    regWrite(0, 8'h42);
    pulse(8'h42); settle();
    checkOut("R3 highest", 1, 6, VB + 6);
    regWrite(4 + 1, 7); settle();
    checkOut("R3 reprioritized", 1, 7, VB + 1);
  endtask

  task automatic testTie();
    doReset();
    regWrite(4 + 2, 4);
    regWrite(4 + 4, 4);
    regWrite(0, 8'h14);
    pulse(8'h14); settle();
    checkOut("R4 tie", 1, 4, VB + 2);
  endtask

  task automatic testLevelZero();
    doReset();
    regWrite(0, 8'h20);
    pulse(8'h20); settle();
    checkOut("R5 level zero", 0, 0, 0);
    regWrite(4 + 5, 1); settle();
    checkOut("R5 level one", 1, 1, VB + 5);
  endtask

  task automatic testDma();
    doReset();
    regWrite(4 + 0, 7);
    regWrite(4 + 5, 2);
    regWrite(0, 8'h21);
    pulse(8'h21); settle();
    checkOut("R7 base", 1, 7, VB + 0);
    regWrite(1, 8'h01); settle();
    checkOut("R7 req bit alone", 1, 7, VB + 0);
    regWrite(2, 8'h01); settle();
    checkOut("R7 diverted", 1, 2, VB + 5);
    regWrite(1, 8'h00); settle();
    checkOut("R7 en bit alone", 1, 7, VB + 0);
  endtask

  task automatic testClear();
    doReset();
    regWrite(4 + 1, 2);
    regWrite(4 + 3, 5);
    regWrite(0, 8'h0A);
    pulse(8'h0A); settle();
    checkOut("R8 both", 1, 5, VB + 3);
    regWrite(3, 8'h08); settle();
    checkOut("R8 clear one", 1, 2, VB + 1);
    regWrite(3, 8'h00); settle();
    checkOut("R8 zero write", 1, 2, VB + 1);
    regWrite(3, 8'h02); settle();
    checkOut("R8 clear all", 0, 0, 0);
  endtask

  task automatic testSetWins();
    doReset();
    regWrite(4 + 2, 3);
    regWrite(4 + 5, 6);
    regWrite(0, 8'h24);
    pulse(8'h24); settle();
    checkOut("R9 before", 1, 6, VB + 5);
    @(negedge clk);
    srcTrig = 8'h04; wrEn = 1'b1; wrAddr = 4'd3; wrData = 8'h24;
    @(negedge clk);
    srcTrig = '0; wrEn = 1'b0; wrAddr = '0; wrData = '0;
    settle();
    checkOut("R9 set wins", 1, 3, VB + 2);
  endtask

  initial begin
    #800000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    testReset();
    testSingleAndLatency();
    testEnableLatch();
    testPriority();
    testTie();
    testLevelZero();
    testDma();
    testClear();
    testSetWins();
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule